// File: doc/BRIEF.md
# Edge-Interrupt GPIO Bank

A bank of 32 general-purpose pins behind a small memory-mapped register port. Software programs each pin's output level and whether it drives the pad. Set and clear alias addresses give single-write updates of individual bits, so no read-modify-write sequence is needed. A pair of selector registers picks one of four pin functions: plain GPIO or one of three alternate functions.

Pad inputs pass through a two-flop synchroniser. Each synchronised level is compared with its value one cycle earlier to find rising and falling edges. Separate rising and falling enables feed a sticky interrupt status, which software clears by writing ones. A second, independent pair of rising and falling masks feeds a sticky wake status. The interrupt output is the OR of its status bits, and the wake output is the OR of its own.

The register port is a single-cycle bus. A write takes effect on the clock edge at which it is presented. Read data is combinational from the address while the select is high and write-enable is low.

Top module: `gpio_bank`

## Requirements
- R1: After reset every register is zero, so pad_out, pad_oe, alt_mode, irq and wake are all low.
- R2: A write to 0x00 loads the output data register. Ones written to 0x04 set the matching data bits, and ones written to 0x08 clear them. Zero bits in an alias write leave the register unchanged. pad_out shows the data register from the clock edge of the write.
- R3: The direction register works the same way, with load at 0x10, set at 0x14 and clear at 0x18. A 1 makes the pin an output (pad_oe high), and reading 0x10 returns the register.
- R4: Reading 0x00 returns the synchronised pad level, whatever the pin's direction. A pad change becomes visible after the second rising clock edge.
- R5: Selector A is at 0x20 and selector B is at 0x24, and both read back. For pin i, alt_mode[2i+1:2i] = {B[i], A[i]}: 0 is GPIO, 1 is function A, 2 is function B and 3 is function C.
- R6: The rising-edge enable is at 0x40 and the falling-edge enable at 0x44. An enabled edge sets its bit in the status register at 0x48 on the third rising clock edge after the pad change. An edge whose enable is clear sets nothing.
- R7: Writing ones to 0x4C clears the matching status bits, and zero bits leave status unchanged. When an edge and a clear hit the same bit in the same cycle, the bit stays set.
- R8: irq is high exactly when any interrupt status bit is set.
- R9: The rising wake mask is at 0x50 and the falling wake mask at 0x54. Matching edges set bits of the wake status at 0x58, independently of the interrupt enables. Writing ones to 0x58 clears them, and wake is the OR of the wake status.
- R10: Reads of the alias addresses (0x04, 0x08, 0x14, 0x18, 0x4C) and of unmapped addresses return zero. Writes to 0x48 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data (combinational) |
| pad_in | input | 32 | Pad input levels |
| pad_out | output | 32 | Pad output values |
| pad_oe | output | 32 | Pad output enables |
| alt_mode | output | 64 | Two-bit function select per pin |
| irq | output | 1 | Interrupt request |
| wake | output | 1 | Wake request |

## Verification
The assertions assume the bus presents at most one access per cycle, with known address and data whenever the select is high. They also assume pad inputs hold steady through reset, so the synchroniser does not see a spurious edge on release. The stimulus drives every bus and pad change on the falling clock edge, holds the pads at zero during reset, and changes only the pins under test so that each edge is attributable. The same-cycle edge-and-clear case is timed so that the clear write lands on exactly the edge that latches the new event.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
    localparam int NPINS  = 32;
    localparam int ADDR_W = 8;

    localparam logic [ADDR_W-1:0] OFS_DATA     = 8'h00;
    localparam logic [ADDR_W-1:0] OFS_DATA_SET = 8'h04;
    localparam logic [ADDR_W-1:0] OFS_DATA_CLR = 8'h08;
    localparam logic [ADDR_W-1:0] OFS_DIR      = 8'h10;
    localparam logic [ADDR_W-1:0] OFS_DIR_SET  = 8'h14;
    localparam logic [ADDR_W-1:0] OFS_DIR_CLR  = 8'h18;
    localparam logic [ADDR_W-1:0] OFS_SEL_A    = 8'h20;
    localparam logic [ADDR_W-1:0] OFS_SEL_B    = 8'h24;
    localparam logic [ADDR_W-1:0] OFS_RISE_EN  = 8'h40;
    localparam logic [ADDR_W-1:0] OFS_FALL_EN  = 8'h44;
    localparam logic [ADDR_W-1:0] OFS_EVT_STS  = 8'h48;
    localparam logic [ADDR_W-1:0] OFS_EVT_CLR  = 8'h4C;
    localparam logic [ADDR_W-1:0] OFS_WK_RISE  = 8'h50;
    localparam logic [ADDR_W-1:0] OFS_WK_FALL  = 8'h54;
    localparam logic [ADDR_W-1:0] OFS_WK_STS   = 8'h58;

    typedef enum logic [1:0] {
        PIN_FN_GPIO = 2'd0,
        PIN_FN_A    = 2'd1,
        PIN_FN_B    = 2'd2,
        PIN_FN_C    = 2'd3
    } pin_fn_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pad_i,
    output logic [W-1:0] level_o,
    output logic [W-1:0] rise_o,
    output logic [W-1:0] fall_o
);
    logic [W-1:0] meta_q;
    logic [W-1:0] lvl_q;
    logic [W-1:0] prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= '0;
            lvl_q  <= '0;
            prev_q <= '0;
        end else begin
            meta_q <= pad_i;
            lvl_q  <= meta_q;
            prev_q <= lvl_q;
        end
    end

    assign level_o = lvl_q;
    assign rise_o  = lvl_q & ~prev_q;
    assign fall_o  = ~lvl_q & prev_q;
endmodule

// File: rtl/gpio_alias_reg.sv
module gpio_alias_reg #(
    parameter int W  = 32,
    parameter int AW = 8,
    parameter logic [AW-1:0] LOAD_ADDR = '0,
    parameter logic [AW-1:0] SET_ADDR  = '0,
    parameter logic [AW-1:0] CLR_ADDR  = '0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] addr,
    input  logic [W-1:0]  wdata,
    output logic [W-1:0]  q
);
    logic [W-1:0] d;
    logic         hit_load, hit_set, hit_clr;

    assign hit_load = wr_en && (addr == LOAD_ADDR);
    assign hit_set  = wr_en && (addr == SET_ADDR);
    assign hit_clr  = wr_en && (addr == CLR_ADDR);

    always_comb begin
        d = q;
        if (hit_load)     d = wdata;
        else if (hit_set) d = q | wdata;
        else if (hit_clr) d = q & ~wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    // R2 for the data instance, R3 for the direction instance
    assert_alias_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == SET_ADDR) |=>
            ((q & $past(wdata)) == $past(wdata)) &&
            ((q & ~$past(wdata)) == ($past(q) & ~$past(wdata))));

    assert_alias_clr_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == CLR_ADDR) |=>
            ((q & $past(wdata)) == '0) &&
            ((q & ~$past(wdata)) == ($past(q) & ~$past(wdata))));

    assert_alias_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && (addr == LOAD_ADDR || addr == SET_ADDR || addr == CLR_ADDR))
            |=> $stable(q));
endmodule

// File: rtl/gpio_plain_reg.sv
module gpio_plain_reg #(
    parameter int W  = 32,
    parameter int AW = 8,
    parameter logic [AW-1:0] ADDR = '0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] addr,
    input  logic [W-1:0]  wdata,
    output logic [W-1:0]  q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                      q <= '0;
        else if (wr_en && addr == ADDR)  q <= wdata;
    end
endmodule

// File: rtl/gpio_evt_latch.sv
module gpio_evt_latch #(
    parameter int W  = 32,
    parameter int AW = 8,
    parameter logic [AW-1:0] CLR_ADDR = '0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [W-1:0]  set_i,
    input  logic          wr_en,
    input  logic [AW-1:0] addr,
    input  logic [W-1:0]  wdata,
    output logic [W-1:0]  sts_o,
    output logic          any_o
);
    logic [W-1:0] clr;

    assign clr = (wr_en && addr == CLR_ADDR) ? wdata : '0;

    // a fresh event outranks a clear landing in the same cycle
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sts_o <= '0;
        else        sts_o <= (sts_o & ~clr) | set_i;
    end

    assign any_o = |sts_o;

    // R7 (interrupt instance) and R9 (wake instance): sticky until cleared
    assert_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((sts_o & $past(sts_o & ~clr)) == $past(sts_o & ~clr)));

    // R6: a bit only rises when its event fired
    assert_set_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((sts_o & ~$past(sts_o) & ~$past(set_i)) == '0));

    // R7: an event wins over a simultaneous clear
    assert_evt_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((sts_o & $past(set_i)) == $past(set_i)));
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
    import gpio_pkg::*;
#(
    parameter int W  = NPINS,
    parameter int AW = ADDR_W
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            bus_sel,
    input  logic            bus_we,
    input  logic [AW-1:0]   bus_addr,
    input  logic [W-1:0]    bus_wdata,
    output logic [W-1:0]    bus_rdata,
    input  logic [W-1:0]    pad_in,
    output logic [W-1:0]    pad_out,
    output logic [W-1:0]    pad_oe,
    output logic [2*W-1:0]  alt_mode,
    output logic            irq,
    output logic            wake
);
    localparam int FN_W = 2;

    logic          wr_en;
    logic [W-1:0]  lvl, rise, fall;
    logic [W-1:0]  data_q, dir_q, sel_a_q, sel_b_q;
    logic [W-1:0]  rise_en_q, fall_en_q, wk_rise_q, wk_fall_q;
    logic [W-1:0]  evt_set, wk_set, evt_sts, wk_sts;
    logic          evt_any, wk_any;

    assign wr_en = bus_sel && bus_we;

    gpio_sync #(.W(W)) u_sync (
        .clk(clk), .rst_n(rst_n), .pad_i(pad_in),
        .level_o(lvl), .rise_o(rise), .fall_o(fall)
    );

    gpio_alias_reg #(.W(W), .AW(AW), .LOAD_ADDR(OFS_DATA),
                     .SET_ADDR(OFS_DATA_SET), .CLR_ADDR(OFS_DATA_CLR)) u_data (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(bus_addr),
        .wdata(bus_wdata), .q(data_q)
    );

    gpio_alias_reg #(.W(W), .AW(AW), .LOAD_ADDR(OFS_DIR),
                     .SET_ADDR(OFS_DIR_SET), .CLR_ADDR(OFS_DIR_CLR)) u_dir (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(bus_addr),
        .wdata(bus_wdata), .q(dir_q)
    );

    gpio_plain_reg #(.W(W), .AW(AW), .ADDR(OFS_SEL_A)) u_sel_a (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(bus_addr),
        .wdata(bus_wdata), .q(sel_a_q));
    gpio_plain_reg #(.W(W), .AW(AW), .ADDR(OFS_SEL_B)) u_sel_b (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(bus_addr),
        .wdata(bus_wdata), .q(sel_b_q));
    gpio_plain_reg #(.W(W), .AW(AW), .ADDR(OFS_RISE_EN)) u_rise_en (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(bus_addr),
        .wdata(bus_wdata), .q(rise_en_q));
    gpio_plain_reg #(.W(W), .AW(AW), .ADDR(OFS_FALL_EN)) u_fall_en (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(bus_addr),
        .wdata(bus_wdata), .q(fall_en_q));
    gpio_plain_reg #(.W(W), .AW(AW), .ADDR(OFS_WK_RISE)) u_wk_rise (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(bus_addr),
        .wdata(bus_wdata), .q(wk_rise_q));
    gpio_plain_reg #(.W(W), .AW(AW), .ADDR(OFS_WK_FALL)) u_wk_fall (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(bus_addr),
        .wdata(bus_wdata), .q(wk_fall_q));

    assign evt_set = (rise & rise_en_q) | (fall & fall_en_q);
    assign wk_set  = (rise & wk_rise_q) | (fall & wk_fall_q);

    gpio_evt_latch #(.W(W), .AW(AW), .CLR_ADDR(OFS_EVT_CLR)) u_evt (
        .clk(clk), .rst_n(rst_n), .set_i(evt_set), .wr_en(wr_en),
        .addr(bus_addr), .wdata(bus_wdata), .sts_o(evt_sts), .any_o(evt_any)
    );

    gpio_evt_latch #(.W(W), .AW(AW), .CLR_ADDR(OFS_WK_STS)) u_wk (
        .clk(clk), .rst_n(rst_n), .set_i(wk_set), .wr_en(wr_en),
        .addr(bus_addr), .wdata(bus_wdata), .sts_o(wk_sts), .any_o(wk_any)
    );

    assign pad_out = data_q;
    assign pad_oe  = dir_q;
    assign irq     = evt_any;
    assign wake    = wk_any;

    for (genvar p = 0; p < W; p++) begin : g_fn
        pin_fn_e fn;
        assign fn = pin_fn_e'({sel_b_q[p], sel_a_q[p]});
        assign alt_mode[p*FN_W +: FN_W] = fn;
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_sel && !bus_we) begin
            case (bus_addr)
                OFS_DATA:    bus_rdata = lvl;
                OFS_DIR:     bus_rdata = dir_q;
                OFS_SEL_A:   bus_rdata = sel_a_q;
                OFS_SEL_B:   bus_rdata = sel_b_q;
                OFS_RISE_EN: bus_rdata = rise_en_q;
                OFS_FALL_EN: bus_rdata = fall_en_q;
                OFS_EVT_STS: bus_rdata = evt_sts;
                OFS_WK_RISE: bus_rdata = wk_rise_q;
                OFS_WK_FALL: bus_rdata = wk_fall_q;
                OFS_WK_STS:  bus_rdata = wk_sts;
                default:     bus_rdata = '0;
            endcase
        end
    end

    // R8: the interrupt only rises after an enabled edge
    assert_irq_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(|evt_set));

    // R9: the wake request only rises after a masked-in edge
    assert_wake_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wake) |-> $past(|wk_set));
endmodule

// File: tb/tb_gpio_bank.sv
`timescale 1ns/1ps
module tb_gpio_bank;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0, bus_we = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0, bus_rdata;
    logic [31:0] pad_in = '0, pad_out, pad_oe;
    logic [63:0] alt_mode;
    logic        irq, wake;
    int          checks = 0, fails = 0;
    bit          done = 0;

    always #2 clk = ~clk;

    gpio_bank dut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe),
        .alt_mode(alt_mode), .irq(irq), .wake(wake)
    );

    // {write, addr, data}; for reads data is the expected value
    localparam int NV = 16;
    localparam logic [40:0] VEC [NV] = '{
        {1'b1, 8'h10, 32'h0000_FFFF},   // R3 load
        {1'b0, 8'h10, 32'h0000_FFFF},
        {1'b1, 8'h14, 32'hFF00_0000},   // R3 set
        {1'b0, 8'h10, 32'hFF00_FFFF},
        {1'b1, 8'h18, 32'h0000_00F0},   // R3 clear
        {1'b0, 8'h10, 32'hFF00_FF0F},
        {1'b1, 8'h20, 32'h0000_000F},   // R5
        {1'b1, 8'h24, 32'h0000_0033},
        {1'b0, 8'h20, 32'h0000_000F},
        {1'b0, 8'h24, 32'h0000_0033},
        {1'b1, 8'h48, 32'hFFFF_FFFF},   // R10 read-only status
        {1'b0, 8'h48, 32'h0000_0000},
        {1'b0, 8'h04, 32'h0000_0000},   // R10 alias reads zero
        {1'b0, 8'h4C, 32'h0000_0000},
        {1'b1, 8'h40, 32'h0000_0001},   // R6 enable readback
        {1'b0, 8'h40, 32'h0000_0001}
    };

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // called at a falling edge; the write lands on the next rising edge
    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] v);
        bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
        #0.5;
        v = bus_rdata;
        bus_sel = 1'b0;
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic summary;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    initial begin
        #400000;
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog expired");
            summary();
        end
    end

    initial begin
        logic [31:0] v;
        wait_n(3);
        rst_n = 1'b1;
        wait_n(1);

        // R1 reset state
        chk("R1 pad_out", pad_out, 0);
        chk("R1 pad_oe", pad_oe, 0);
        chk("R1 alt_mode", alt_mode, 0);
        chk("R1 irq/wake", {irq, wake}, 0);
        rd(8'h48, v); chk("R1 status", v, 0);

        for (int i = 0; i < NV; i++) begin
            if (VEC[i][40]) wr(VEC[i][39:32], VEC[i][31:0]);
            else begin
                rd(VEC[i][39:32], v);
                chk($sformatf("R3/R5/R6/R10 vector %0d", i), v, VEC[i][31:0]);
            end
        end
        chk("R3 pad_oe", pad_oe, 32'hFF00_FF0F);
        chk("R5 alt_mode", alt_mode[15:0], 16'h0A5F);

        // R2 data load, set and clear aliases
        wr(8'h00, 32'h1234_5678); chk("R2 load", pad_out, 32'h1234_5678);
        wr(8'h04, 32'h8000_0001); chk("R2 set", pad_out, 32'h9234_5679);
        wr(8'h08, 32'h0000_0078); chk("R2 clear", pad_out, 32'h9234_5601);

        // R4 synchronised input readback
        pad_in = 32'hA5A5_0000;
        wait_n(1); rd(8'h00, v); chk("R4 one edge", v, 0);
        wait_n(1); rd(8'h00, v); chk("R4 two edges", v, 32'hA5A5_0000);

        // R6 enabled rising edge on pin0, disabled on pin8
        wr(8'h40, 32'h0000_0003);
        wr(8'h44, 32'h0000_0004);
        pad_in = 32'hA5A5_0101;
        wait_n(2); rd(8'h48, v); chk("R6 not yet", v, 0);
        wait_n(1); rd(8'h48, v); chk("R6 rise", v, 32'h1);
        chk("R8 irq high", irq, 1);

        // R7 clear with ones, zeros untouched
        wr(8'h4C, 32'h0000_0002); rd(8'h48, v); chk("R7 zero bits", v, 32'h1);
        wr(8'h4C, 32'h0000_0001); rd(8'h48, v); chk("R7 cleared", v, 0);
        chk("R8 irq low", irq, 0);

        // R6 falling edge on pin2 (its rising edge is not enabled)
        pad_in = 32'hA5A5_0105;
        wait_n(3); rd(8'h48, v); chk("R6 rise disabled", v, 0);
        pad_in = 32'hA5A5_0101;
        wait_n(3); rd(8'h48, v); chk("R6 fall", v, 32'h4);

        // R10 write to status ignored
        wr(8'h48, 32'h0); rd(8'h48, v); chk("R10 status write", v, 32'h4);

        // R7 edge and clear in the same cycle: edge wins
        wr(8'h40, 32'h0000_0007);
        pad_in = 32'hA5A5_0105;
        wait_n(2);
        wr(8'h4C, 32'h0000_0004);
        rd(8'h48, v); chk("R7 edge wins", v, 32'h4);
        wr(8'h4C, 32'hFFFF_FFFF);
        rd(8'h48, v); chk("R7 clear all", v, 0);

        // R9 wake path, independent of interrupt enables
        wr(8'h50, 32'h0000_0100);
        pad_in = 32'hA5A5_0005;
        wait_n(3); chk("R9 fall masked", wake, 0);
        pad_in = 32'hA5A5_0105;
        wait_n(3); chk("R9 wake", wake, 1);
        rd(8'h58, v); chk("R9 wake status", v, 32'h100);
        rd(8'h48, v); chk("R9 irq status untouched", v, 0);
        wr(8'h58, 32'h0000_0100); chk("R9 wake cleared", wake, 0);

        done = 1;
        summary();
    end
endmodule